// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Edge Interrupts

This block is one configurable I/O port of `N_PINS` pins (eight by default) as a CPU sees it over a small register bus. Software writes output values into a data register. It reads the pin levels back through a separate, synchronized pin-state register. Because of this split, a read-modify-write of the data register never picks up the level of a pin that an outside source is driving. Each pin has a 3-bit drive-mode code. The code decides whether the pin's output enable follows the data bit, is held off, or is held on. The data and drive-mode registers leave reset with values set by parameters, so an instance can choose the pin states it presents after reset.

Every pin input passes through a two-flop synchronizer and then an edge detector. Each pin selects rising, falling, both or no edges. A qualifying edge sets that pin's sticky status bit. The port has one interrupt line, which is the OR of all status bits. Reading the port-wide status register returns the bits and clears them. Configuration is reachable in two ways: port-wide registers that hold one field for all pins, and one register per pin that holds all of that pin's fields.

The register bus is plain control traffic and has no back-pressure. A request is accepted in the cycle `bus_valid` is high. Read data comes back one cycle later, marked by a one-cycle `bus_rvalid` pulse. There is no ready signal, so a request can be issued in every cycle.

Top module: `gpio_port`

## Requirements
- R1: After reset the data register equals parameter `OUT_RST`, pin i's drive mode equals bits [3i+2:3i] of `MODE_RST`, all edge enables are 0, the status register is 0 and `irq` is 0.
- R2: A write to address 0x00 loads the data register, and `pin_out` follows it from the next cycle. A read of 0x00 returns the data register, never the pin levels.
- R3: A read of address 0x01 returns the pin inputs after two synchronizer flops: a change of `pin_in` set up before clock edge A is returned by a read sampled at edge A+2 but not by one sampled at edge A+1. Writes to 0x01 have no effect.
- R4: Output enable per drive mode: codes 0 and 1 are high impedance (oe 0 whatever the data bit); codes 2 and 4 drive only a low level (oe = not data); codes 3 and 5 drive only a high level (oe = data); codes 6 and 7 always drive (oe 1).
- R5: Pin i's edge select is {fall, rise}: 00 none, 01 rising, 10 falling, 11 both. Bit i of the port-wide register 0x02 is the rise enable and bit i of 0x03 is the fall enable.
- R6: A qualifying edge sets pin i's status bit. `irq` is the OR of the status bits and goes high after clock edge A+2 for a pin change set up before edge A.
- R7: A read of address 0x04 returns the status register and clears every bit whose edge does not arrive in that same cycle. An edge that arrives in the cycle of the clearing read leaves its bit set. Writes to 0x04 have no effect.
- R8: Address 0x10+i is pin i's own register: bit 0 data, bits 3:1 drive mode, bit 4 rise enable, bit 5 fall enable, bit 6 synchronized pin level, and bit 7 status. Bits 6 and 7 are read-only. Reading it does not clear the status bit. A write changes only pin i.
- R9: Addresses 0x05, 0x06 and 0x07 are drive-mode bit planes: bit i of address 0x05+b is bit b of pin i's mode code, for both reads and writes.
- R10: Read data is valid exactly one cycle after the read request, flagged by a one-cycle `bus_rvalid`. Unmapped addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | max(N_PINS,8) | Write data |
| bus_rdata | output | max(N_PINS,8) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | N_PINS | Asynchronous pin levels |
| pin_out | output | N_PINS | Output data to the pads |
| pin_oe | output | N_PINS | Output enables to the pads |
| irq | output | 1 | Port interrupt request |

## Verification
Drive modes are swept over all eight codes with two complementary data patterns. This separates the modes whose enable ignores the data bit from those where it follows the data bit or its inverse. The edge logic is tried with each of the four select codes applied to every pin, on both a rising and a falling transition. This shows whether each direction is qualified independently. A mixed pattern gives each pin a different select code through its own register, which exposes any crosstalk between pins or between the two access paths. Edges timed to coincide with a clearing read, and reads placed one cycle either side of the synchronizer latency, check the ordering rules.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 5;
  localparam int MODE_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] ADDR_OUT    = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_PIN    = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_RISE   = 5'h02;
  localparam logic [ADDR_W-1:0] ADDR_FALL   = 5'h03;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_MODE0  = 5'h05;
  localparam logic [ADDR_W-1:0] ADDR_MODE1  = 5'h06;
  localparam logic [ADDR_W-1:0] ADDR_MODE2  = 5'h07;

  typedef enum logic [MODE_W-1:0] {
    DM_HIZ_ANALOG  = 3'd0,
    DM_HIZ_DIGITAL = 3'd1,
    DM_PULL_UP     = 3'd2,
    DM_PULL_DOWN   = 3'd3,
    DM_SINK_ONLY   = 3'd4,
    DM_SOURCE_ONLY = 3'd5,
    DM_STRONG      = 3'd6,
    DM_STRONG_PULL = 3'd7
  } drive_mode_e;

  function automatic logic mode_drives(input drive_mode_e m, input logic d);
    case (m)
      DM_HIZ_ANALOG, DM_HIZ_DIGITAL: mode_drives = 1'b0;
      DM_PULL_UP, DM_SINK_ONLY:      mode_drives = ~d;
      DM_PULL_DOWN, DM_SOURCE_ONLY:  mode_drives = d;
      default:                       mode_drives = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_now,
  output logic [N_PINS-1:0] rise,
  output logic [N_PINS-1:0] fall
);
  logic [N_PINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign pin_now = sync_q;
  assign rise    = sync_q & ~prev_q;
  assign fall    = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_PINS-1:0][MODE_W-1:0] mode,
  input  logic [N_PINS-1:0]             out_data,
  output logic [N_PINS-1:0]             pin_out,
  output logic [N_PINS-1:0]             pin_oe
);
  assign pin_out = out_data;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pin_oe[i] = mode_drives(drive_mode_e'(mode[i]), out_data[i]);

    // R4: high-impedance codes never enable the driver
    assert_hiz_oe_R4: assert property (@(posedge clk) disable iff (rst)
      (mode[i] == DM_HIZ_ANALOG || mode[i] == DM_HIZ_DIGITAL) |-> !pin_oe[i]);
    // R4: strong codes always enable the driver
    assert_strong_oe_R4: assert property (@(posedge clk) disable iff (rst)
      (mode[i] == DM_STRONG || mode[i] == DM_STRONG_PULL) |-> pin_oe[i]);
  end

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] rise,
  input  logic [N_PINS-1:0] fall,
  input  logic [N_PINS-1:0] rise_en,
  input  logic [N_PINS-1:0] fall_en,
  input  logic              stat_clr,
  output logic [N_PINS-1:0] status,
  output logic              irq
);
  logic [N_PINS-1:0] hit;
  logic [N_PINS-1:0] status_q;

  assign hit = (rise & rise_en) | (fall & fall_en);

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~{N_PINS{stat_clr}}) | hit;
  end

  assign status = status_q;
  assign irq    = |status_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    // R6: a status bit only comes up after a qualifying edge
    assert_set_by_edge_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(status_q[i]) && status_q[i]) |-> $past(hit[i]));
    // R7: a clearing read without a same-cycle edge leaves the bit low
    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(stat_clr) && !$past(hit[i])) |-> !status_q[i]);
    // R7: an edge that meets the clearing read wins
    assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
      $past(hit[i]) |-> status_q[i]);
  end

  // R6: the port line rises only after some pin saw an edge
  assert_irq_needs_edge_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|hit));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int                     N_PINS   = 8,
  parameter logic [N_PINS-1:0]      OUT_RST  = '0,
  parameter logic [3*N_PINS-1:0]    MODE_RST = {N_PINS{3'd1}},
  localparam int                    DW       = (N_PINS > 8) ? N_PINS : 8,
  localparam int                    IW       = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DW-1:0]                 bus_wdata,
  output logic [DW-1:0]                 bus_rdata,
  output logic                          bus_rvalid,
  input  logic [N_PINS-1:0]             pin_now,
  input  logic [N_PINS-1:0]             status,
  output logic [N_PINS-1:0]             out_q,
  output logic [N_PINS-1:0][MODE_W-1:0] mode_q,
  output logic [N_PINS-1:0]             rise_en,
  output logic [N_PINS-1:0]             fall_en,
  output logic                          stat_clr
);
  logic          is_pin;
  logic [IW-1:0] idx;
  logic [1:0]    plane;
  logic          do_wr, do_rd;
  logic [DW-1:0] rd_next;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign is_pin  = bus_addr[4] && ({28'd0, bus_addr[3:0]} < 32'(N_PINS));
  assign idx     = bus_addr[IW-1:0];
  assign plane   = 2'(bus_addr - ADDR_MODE0);
  assign do_wr   = bus_valid && bus_write;
  assign do_rd   = bus_valid && !bus_write;
  assign stat_clr = do_rd && (bus_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= OUT_RST;
      mode_q  <= MODE_RST;
      rise_en <= '0;
      fall_en <= '0;
    end else if (do_wr) begin
      if (is_pin) begin
        out_q[idx]   <= bus_wdata[0];
        mode_q[idx]  <= bus_wdata[3:1];
        rise_en[idx] <= bus_wdata[4];
        fall_en[idx] <= bus_wdata[5];
      end else begin
        case (bus_addr)
          ADDR_OUT:  out_q   <= bus_wdata[N_PINS-1:0];
          ADDR_RISE: rise_en <= bus_wdata[N_PINS-1:0];
          ADDR_FALL: fall_en <= bus_wdata[N_PINS-1:0];
          ADDR_MODE0, ADDR_MODE1, ADDR_MODE2: begin
            for (int i = 0; i < N_PINS; i++) mode_q[i][plane] <= bus_wdata[i];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (is_pin) begin
      rd_next[0]   = out_q[idx];
      rd_next[3:1] = mode_q[idx];
      rd_next[4]   = rise_en[idx];
      rd_next[5]   = fall_en[idx];
      rd_next[6]   = pin_now[idx];
      rd_next[7]   = status[idx];
    end else begin
      case (bus_addr)
        ADDR_OUT:  rd_next[N_PINS-1:0] = out_q;
        ADDR_PIN:  rd_next[N_PINS-1:0] = pin_now;
        ADDR_RISE: rd_next[N_PINS-1:0] = rise_en;
        ADDR_FALL: rd_next[N_PINS-1:0] = fall_en;
        ADDR_STAT: rd_next[N_PINS-1:0] = status;
        ADDR_MODE0, ADDR_MODE1, ADDR_MODE2: begin
          for (int i = 0; i < N_PINS; i++) rd_next[i] = mode_q[i][plane];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= do_rd;
      if (do_rd) bus_rdata <= rd_next;
    end
  end

  // R10: read data is flagged exactly one cycle after the request
  assert_rvalid_timing_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid == $past(do_rd));
  // R2: a port-wide data write lands in the data register
  assert_out_write_R2: assert property (@(posedge clk) disable iff (rst)
    $past(do_wr && bus_addr == ADDR_OUT) |-> out_q == $past(bus_wdata[N_PINS-1:0]));
  // R3: a write to the pin-state address leaves the data register alone
  assert_pin_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    $past(do_wr && bus_addr == ADDR_PIN) |-> $stable(out_q));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int                  N_PINS   = 8,
  parameter logic [N_PINS-1:0]   OUT_RST  = '0,
  parameter logic [3*N_PINS-1:0] MODE_RST = {N_PINS{3'd1}},
  localparam int                 DW       = (N_PINS > 8) ? N_PINS : 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [4:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);
  logic [N_PINS-1:0]             pin_now, rise, fall;
  logic [N_PINS-1:0]             status, out_q, rise_en, fall_en;
  logic [N_PINS-1:0][MODE_W-1:0] mode_q;
  logic                          stat_clr;

  gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .pin_now(pin_now), .rise(rise), .fall(fall)
  );

  gpio_regs #(.N_PINS(N_PINS), .OUT_RST(OUT_RST), .MODE_RST(MODE_RST)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_now(pin_now), .status(status),
    .out_q(out_q), .mode_q(mode_q), .rise_en(rise_en), .fall_en(fall_en),
    .stat_clr(stat_clr)
  );

  gpio_irq #(.N_PINS(N_PINS)) u_irq (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall),
    .rise_en(rise_en), .fall_en(fall_en), .stat_clr(stat_clr),
    .status(status), .irq(irq)
  );

  gpio_drive #(.N_PINS(N_PINS)) u_drive (
    .clk(clk), .rst(rst), .mode(mode_q), .out_data(out_q),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R1: the port is quiet in the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && status == '0));

endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int N = 8;
  localparam logic [7:0]  ORST = 8'hA5;
  localparam logic [23:0] MRST = {3'd6,3'd1,3'd6,3'd1,3'd6,3'd1,3'd6,3'd1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_port #(.N_PINS(N), .OUT_RST(ORST), .MODE_RST(MRST)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic m_oe(input logic [2:0] m, input logic d);
    case (m)
      3'd0, 3'd1: m_oe = 1'b0;
      3'd2, 3'd4: m_oe = !d;
      3'd3, 3'd5: m_oe = d;
      default:    m_oe = 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    total++;
    if (bus_rvalid !== 1'b1) begin
      bad++;
      $display("FAIL R10 rvalid actual=%b expected=1", bus_rvalid);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r, exp_oe, p;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(5'h00, r); chk("R1 out reset", r, ORST);
    chk("R1 pin_out reset", pin_out, ORST);
    chk("R1 oe reset", pin_oe, 8'hAA);
    chk("R1 irq reset", irq, 0);
    rd(5'h04, r); chk("R1 status reset", r, 0);
    rd(5'h02, r); chk("R1 rise reset", r, 0);
    rd(5'h03, r); chk("R1 fall reset", r, 0);
    rd(5'h05, r); chk("R1 R9 plane0 reset", r, 8'h55);
    rd(5'h06, r); chk("R1 R9 plane1 reset", r, 8'hAA);
    rd(5'h07, r); chk("R1 R9 plane2 reset", r, 8'hAA);

    // R2: data register separate from pins
    wr(5'h00, 8'h3C);
    chk("R2 pin_out", pin_out, 8'h3C);
    pin_in = 8'hC3; idle(4);
    rd(5'h00, r); chk("R2 read data not pins", r, 8'h3C);

    // R3: synchronizer latency of two flops
    @(negedge clk);
    pin_in = 8'h5A; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'h01;
    @(negedge clk); chk("R3 read at A", bus_rdata, 8'hC3);
    @(negedge clk); chk("R3 read at A+1", bus_rdata, 8'hC3);
    @(negedge clk); chk("R3 read at A+2", bus_rdata, 8'h5A);
    bus_valid = 1'b0;
    wr(5'h01, 8'hFF);
    rd(5'h01, r); chk("R3 pin write ignored", r, 8'h5A);
    rd(5'h00, r); chk("R3 data unchanged by pin write", r, 8'h3C);

    // R4 R9: every drive mode with two data patterns
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] d;
        d = k[0] ? 8'hAA : 8'h55;
        wr(5'h00, d);
        for (int b = 0; b < 3; b++) wr(5'(5 + b), m[b] ? 8'hFF : 8'h00);
        for (int i = 0; i < 8; i++) exp_oe[i] = m_oe(3'(m), d[i]);
        chk($sformatf("R4 oe mode %0d data %h", m, d), pin_oe, exp_oe);
        chk("R2 pin_out follows data", pin_out, d);
      end
      rd(5'h05, r); chk("R9 plane0 readback", r, m[0] ? 8'hFF : 8'h00);
    end

    // R5 R6 R7: each edge select applied to every pin
    pin_in = 8'h00; wr(5'h02, 8'h00); wr(5'h03, 8'h00); idle(4);
    rd(5'h04, r);
    for (int e = 0; e < 4; e++) begin
      p = 8'h3C ^ 8'(e * 8'h11);
      wr(5'h02, e[0] ? 8'hFF : 8'h00);
      wr(5'h03, e[1] ? 8'hFF : 8'h00);
      @(negedge clk); pin_in = p;
      @(negedge clk);
      @(negedge clk); chk("R6 irq not before A+2", irq, 0);
      @(negedge clk); chk($sformatf("R6 irq after rise sel %0d", e), irq, e[0] ? 1 : 0);
      rd(5'h04, r); chk($sformatf("R5 rise status sel %0d", e), r, e[0] ? p : 8'h00);
      chk("R7 irq cleared by read", irq, 0);
      @(negedge clk); pin_in = 8'h00; idle(4);
      chk($sformatf("R6 irq after fall sel %0d", e), irq, e[1] ? 1 : 0);
      rd(5'h04, r); chk($sformatf("R5 fall status sel %0d", e), r, e[1] ? p : 8'h00);
      rd(5'h04, r); chk("R7 status empty after read", r, 0);
    end

    // R8: per-pin registers, pin i gets select i%4 and mode i
    wr(5'h02, 8'h00); wr(5'h03, 8'h00);
    for (int b = 0; b < 3; b++) wr(5'(5 + b), 8'hFF);
    for (int i = 0; i < 8; i++)
      wr(5'(16 + i), {2'b00, i[1], i[0], i[2:0], i[0]});
    rd(5'h02, r); chk("R8 R5 rise mask", r, 8'hAA);
    rd(5'h03, r); chk("R8 R5 fall mask", r, 8'hCC);
    rd(5'h05, r); chk("R8 plane0", r, 8'hAA);
    rd(5'h06, r); chk("R8 plane1", r, 8'hCC);
    rd(5'h07, r); chk("R8 plane2", r, 8'hF0);
    rd(5'h00, r); chk("R8 data", r, 8'hAA);
    for (int i = 0; i < 8; i++) exp_oe[i] = m_oe(3'(i), i[0]);
    chk("R8 R4 oe mixed", pin_oe, exp_oe);
    @(negedge clk); pin_in = 8'hFF; idle(4);
    rd(5'h13, r); chk("R8 pin3 register", r, {1'b1, 1'b1, 2'b11, 3'd3, 1'b1});
    rd(5'h04, r); chk("R8 status kept after pin read, rise", r, 8'hAA);
    @(negedge clk); pin_in = 8'h00; idle(4);
    rd(5'h04, r); chk("R5 mixed falls", r, 8'hCC);

    // R7: edge meeting the clearing read
    wr(5'h02, 8'hFF);
    @(negedge clk); pin_in = 8'h01; idle(5);
    @(negedge clk); pin_in = 8'h03;
    @(negedge clk);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'h04;
    @(negedge clk); bus_valid = 1'b0;
    chk("R7 read returns old status", bus_rdata, 8'h01);
    chk("R7 irq held by new edge", irq, 1);
    wr(5'h04, 8'h00);
    rd(5'h04, r); chk("R7 same-cycle edge kept, write ignored", r, 8'h02);

    // R10: unmapped addresses
    wr(5'h08, 8'hFF); wr(5'h1F, 8'hFF);
    rd(5'h08, r); chk("R10 unmapped 0x08", r, 0);
    rd(5'h18, r); chk("R10 unmapped 0x18", r, 0);
    rd(5'h00, r); chk("R10 data untouched", r, 8'hAA);
    rd(5'h02, r); chk("R10 rise untouched", r, 8'hFF);
    @(negedge clk); chk("R10 rvalid one cycle", bus_rvalid, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule